// File: doc/BRIEF.md
# UART Interrupt Identification Encoder

This block turns the interrupt conditions of one serial channel into the byte that software reads to find out why the channel interrupted. It takes five source conditions: receive line error, receive data ready, receive character timeout, transmit holding register empty, and modem line change. It also takes an enable bit for each source class, a flag that says whether the channel runs with its FIFOs on, and a strobe that marks a read of the identification byte. Its outputs are that byte and an active-high interrupt line.

Only the most urgent pending source is reported. The low bit of the byte is an active-low "something is pending" flag. The upper two bits mirror the FIFO enable. Because reading the byte is how software acknowledges a transmit-empty interrupt, a read that reports that source silences it. It stays silent until the holding register is written again. The byte itself is combinational, so a read strobe sees the value of the same cycle. The silencing takes effect on the next clock edge.

Top module: `uart_iid_encoder`

## Requirements
- R1: `iid[0]` is 0 when at least one enabled source is pending and 1 when none is.
- R2: `iid[3:1]` carries the code of the single most urgent pending source. From most to least urgent: line error 011, data ready 010, character timeout 110, transmit empty 001, modem change 000. With nothing pending the field is 000, so the byte's low nibble reads 0x1.
- R3: With `fifo_en` at 0, `iid[3]` reads 0 and the character timeout condition is ignored.
- R4: With `fifo_en` at 1 and the timeout being the most urgent pending source, `iid[3:1]` reads 110, so bit 3 is set together with bit 2.
- R5: `iid[5:4]` always reads 00.
- R6: `iid[7:6]` reads 11 when `fifo_en` is 1 and 00 when it is 0.
- R7: A condition counts only when its enable is 1: `en_line` for line error, `en_rxd` for data ready and for the timeout, `en_thre` for transmit empty, `en_modem` for modem change.
- R8: When `iid_rd` is high in a cycle where transmit empty is the reported source and `thr_wr` is low, that source is ignored from the next cycle onward. This lasts until a cycle with `thr_wr` high. A write in the same cycle as such a read leaves the source armed.
- R9: `irq` is 1 exactly when `iid[0]` is 0.
- R10: Reset (`rst_n` low at a clock edge) re-arms the transmit-empty source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_en | input | 1 | Channel runs with FIFOs enabled |
| en_line | input | 1 | Enable for line error source |
| en_rxd | input | 1 | Enable for data ready and timeout sources |
| en_thre | input | 1 | Enable for transmit empty source |
| en_modem | input | 1 | Enable for modem change source |
| line_err | input | 1 | Receive line error condition |
| rx_ready | input | 1 | Receive data available condition |
| rx_timeout | input | 1 | Receive character timeout condition |
| thr_empty | input | 1 | Transmit holding register empty condition |
| modem_chg | input | 1 | Modem line change condition |
| thr_wr | input | 1 | Holding register is being written this cycle |
| iid_rd | input | 1 | Identification byte is being read this cycle |
| iid | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest state to reach is transmit empty silenced while more urgent sources come and go above it. Reaching it needs a read at the exact cycle transmit empty is on top. The read must then be followed by more urgent sources appearing and vanishing, all with no holding-register write. A read with a write in the same cycle is a further hard case. The stimulus first drives these orders as directed steps. It then runs a long random phase in which reads and writes are frequent and `thr_empty` is mostly high, so silenced states recur often. The behavioural model tracks silencing on its own.

// File: rtl/uart_iid_pkg.sv
// Package: shared widths and source codes for the interrupt identification encoder.
// Assumes source index 0 is the most urgent; the index order is the priority order.
package uart_iid_pkg;

    localparam int IID_W   = 8;
    localparam int CODE_W  = 3;
    localparam int NSRC    = 5;

    // Source slots in priority order (0 = most urgent).
    localparam int IDX_LINE  = 0;
    localparam int IDX_RXD   = 1;
    localparam int IDX_TMO   = 2;
    localparam int IDX_THRE  = 3;
    localparam int IDX_MODEM = 4;

    typedef enum logic [CODE_W-1:0] {
        CODE_MODEM = 3'b000,
        CODE_THRE  = 3'b001,
        CODE_RXD   = 3'b010,
        CODE_LINE  = 3'b011,
        CODE_TMO   = 3'b110
    } iid_code_e;

    // Maps a priority slot to the code that identifies it in the byte.
    function automatic logic [CODE_W-1:0] slot_code(input int idx);
        case (idx)
            IDX_LINE:  slot_code = CODE_LINE;
            IDX_RXD:   slot_code = CODE_RXD;
            IDX_TMO:   slot_code = CODE_TMO;
            IDX_THRE:  slot_code = CODE_THRE;
            default:   slot_code = CODE_MODEM;
        endcase
    endfunction

endpackage

// File: rtl/iid_prio_pick.sv
// Fixed-priority picker: grants the lowest-index active request.
// Assumes requests are already qualified by their enables.
module iid_prio_pick #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);

    logic [N:0] seen;

    assign seen[0] = 1'b0;

    // Prefix chain: a slot wins when no more urgent slot requested.
    generate
        for (genvar i = 0; i < N; i++) begin : g_slot
            assign grant[i]  = req[i] & ~seen[i];
            assign seen[i+1] = seen[i] | req[i];
        end
    endgenerate

    assign any = seen[N];

    p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_grant_when_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> $onehot(grant));

endmodule

// File: rtl/iid_code_mux.sv
// Turns a one-hot grant into the identification code of the granted slot.
// Assumes grant is one-hot or zero; zero yields the all-zero code.
module iid_code_mux
    import uart_iid_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]      grant,
    output logic [CODE_W-1:0] code
);

    logic [CODE_W-1:0] term [N];

    // Each slot contributes its code only while granted.
    generate
        for (genvar i = 0; i < N; i++) begin : g_term
            assign term[i] = grant[i] ? slot_code(i) : '0;
        end
    endgenerate

    // OR the gated codes together.
    always_comb begin
        code = '0;
        for (int k = 0; k < N; k++) begin
            code = code | term[k];
        end
    end

endmodule

// File: rtl/iid_thre_latch.sv
// Remembers that a transmit-empty interrupt was acknowledged by a read.
// Assumes a holding-register write in the same cycle takes precedence over a read.
module iid_thre_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic thr_wr,
    input  logic ack_hit,
    output logic quiet
);

    // Set on an acknowledging read, clear on a write or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet <= 1'b0;
        end else if (thr_wr) begin
            quiet <= 1'b0;
        end else if (ack_hit) begin
            quiet <= 1'b1;
        end
    end

    p_wr_rearms_r8: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !quiet);

    p_read_silences_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && !thr_wr) |=> quiet);

    p_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!thr_wr && !ack_hit) |=> $stable(quiet));

endmodule

// File: rtl/uart_iid_encoder.sv
// Interrupt identification encoder for one serial channel.
// Qualifies five source conditions by their enables, picks the most urgent,
// and forms the readable identification byte plus an interrupt line.
// Assumes all inputs are synchronous to clk; the byte is combinational.
module uart_iid_encoder
    import uart_iid_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             en_line,
    input  logic             en_rxd,
    input  logic             en_thre,
    input  logic             en_modem,
    input  logic             line_err,
    input  logic             rx_ready,
    input  logic             rx_timeout,
    input  logic             thr_empty,
    input  logic             modem_chg,
    input  logic             thr_wr,
    input  logic             iid_rd,
    output logic [IID_W-1:0] iid,
    output logic             irq
);

    logic [NSRC-1:0]   req;
    logic [NSRC-1:0]   grant;
    logic              any_pend;
    logic [CODE_W-1:0] code;
    logic              thre_quiet;
    logic              ack_hit;

    // Qualify each raw condition with its enable and mode.
    always_comb begin
        req            = '0;
        req[IDX_LINE]  = en_line  & line_err;
        req[IDX_RXD]   = en_rxd   & rx_ready;
        req[IDX_TMO]   = en_rxd   & rx_timeout & fifo_en;
        req[IDX_THRE]  = en_thre  & thr_empty  & ~thre_quiet;
        req[IDX_MODEM] = en_modem & modem_chg;
    end

    iid_prio_pick #(.N(NSRC)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .grant (grant),
        .any   (any_pend)
    );

    iid_code_mux #(.N(NSRC)) u_mux (
        .grant (grant),
        .code  (code)
    );

    assign ack_hit = iid_rd & grant[IDX_THRE];

    iid_thre_latch u_thre (
        .clk     (clk),
        .rst_n   (rst_n),
        .thr_wr  (thr_wr),
        .ack_hit (ack_hit),
        .quiet   (thre_quiet)
    );

    // Assemble the byte: mode mirror, zero field, code, active-low pending.
    always_comb begin
        iid      = '0;
        iid[7]   = fifo_en;
        iid[6]   = fifo_en;
        iid[3]   = code[2] & fifo_en;
        iid[2:1] = code[1:0];
        iid[0]   = ~any_pend;
    end

    assign irq = any_pend;

    p_legacy_b3_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> !iid[3]);

    p_quiet_thre_r8: assert property (@(posedge clk) disable iff (!rst_n)
        thre_quiet |-> (iid[3:0] != 4'b0010));

    p_line_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_line && line_err) |-> (iid[3:0] == 4'b0110));

    p_irq_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (code != CODE_MODEM || grant[IDX_MODEM]));

endmodule

// File: tb/uart_iid_encoder_tb.sv
module uart_iid_encoder_tb;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_en = 0, en_line = 0, en_rxd = 0, en_thre = 0, en_modem = 0;
    logic line_err = 0, rx_ready = 0, rx_timeout = 0, thr_empty = 0, modem_chg = 0;
    logic thr_wr = 0, iid_rd = 0;
    logic [7:0] iid;
    logic irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit m_quiet = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_iid_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .en_line(en_line), .en_rxd(en_rxd), .en_thre(en_thre), .en_modem(en_modem),
        .line_err(line_err), .rx_ready(rx_ready), .rx_timeout(rx_timeout),
        .thr_empty(thr_empty), .modem_chg(modem_chg),
        .thr_wr(thr_wr), .iid_rd(iid_rd), .iid(iid), .irq(irq)
    );

    // Behavioural expectation of the byte from the requirements.
    function automatic logic [7:0] expect_iid();
        logic [7:0] v;
        v = fifo_en ? 8'hC0 : 8'h00;                                         // R6, R5
        if (en_line && line_err)                      v = v | 8'h06;         // R2
        else if (en_rxd && rx_ready)                  v = v | 8'h04;
        else if (fifo_en && en_rxd && rx_timeout)     v = v | 8'h0C;         // R3, R4
        else if (en_thre && thr_empty && !m_quiet)    v = v | 8'h02;         // R8
        else if (en_modem && modem_chg)               v = v | 8'h00;
        else                                          v = v | 8'h01;         // R1
        return v;
    endfunction

    task automatic check(input string req, input logic [7:0] exp_v);
        n_tests++;
        if (iid !== exp_v) begin
            n_fail++;
            $display("FAIL %s iid actual=%02h expected=%02h", req, iid, exp_v);
        end
        n_tests++;
        if (irq !== ~exp_v[0]) begin
            n_fail++;
            $display("FAIL R9 irq actual=%0b expected=%0b", irq, ~exp_v[0]);
        end
    endtask

    // Model state update on the clock edge (R8, R10).
    always @(posedge clk) begin
        logic [7:0] cur;
        cur = expect_iid();
        if (!rst_n)                                  m_quiet = 0;
        else if (thr_wr)                             m_quiet = 0;
        else if (iid_rd && cur[3:0] == 4'h2)         m_quiet = 1;
    end

    // Compare against the model on every cycle, away from the edge.
    always @(negedge clk) begin
        if (!done) begin
            #1;
            check("model", expect_iid());
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clr_src();
        line_err = 0; rx_ready = 0; rx_timeout = 0; thr_empty = 0; modem_chg = 0;
        thr_wr = 0; iid_rd = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R10: read during reset must not silence transmit empty.
        en_thre = 1; thr_empty = 1; iid_rd = 1;
        repeat (3) @(negedge clk);
        iid_rd = 0; rst_n = 1;
        #2; check("R10 after reset", 8'h02);

        // R1/R7: all disabled -> nothing pending.
        step(); en_line = 0; en_rxd = 0; en_thre = 0; en_modem = 0;
        line_err = 1; rx_ready = 1; rx_timeout = 1; modem_chg = 1;
        #2; check("R7 disabled", 8'h01);

        // R2 priority walk in FIFO mode.
        step(); fifo_en = 1; en_line = 1; en_rxd = 1; en_thre = 1; en_modem = 1;
        #2; check("R2 line", 8'hC6);
        step(); line_err = 0; #2; check("R2 rxd", 8'hC4);
        step(); rx_ready = 0; #2; check("R4 timeout", 8'hCC);
        step(); rx_timeout = 0; #2; check("R2 thre", 8'hC2);
        step(); thr_empty = 0; #2; check("R2 modem", 8'hC0);

        // R3: legacy mode ignores timeout, bits 7:6 clear (R6).
        step(); clr_src(); fifo_en = 0; rx_timeout = 1; #2; check("R3 legacy", 8'h01);
        step(); modem_chg = 1; #2; check("R3 legacy modem", 8'h00);

        // R8: read acknowledges transmit empty, write re-arms.
        step(); clr_src(); thr_empty = 1; iid_rd = 1; #2; check("R8 before ack", 8'h02);
        step(); iid_rd = 0; #2; check("R8 silenced", 8'h01);
        step(); line_err = 1; #2; check("R8 over line", 8'h06);
        step(); line_err = 0; #2; check("R8 still silent", 8'h01);
        step(); thr_wr = 1; #2; check("R8 write", 8'h01);
        step(); thr_wr = 0; #2; check("R8 rearmed", 8'h02);
        step(); iid_rd = 1; thr_wr = 1; #2; check("R8 rd+wr", 8'h02);
        step(); iid_rd = 0; thr_wr = 0; #2; check("R8 rd+wr armed", 8'h02);
        // Read while another source is reported does not silence.
        step(); rx_ready = 1; iid_rd = 1; #2; check("R8 other read", 8'h04);
        step(); iid_rd = 0; rx_ready = 0; #2; check("R8 not silenced", 8'h02);

        // Random phase; the negedge comparator checks every cycle (R1-R9).
        for (int i = 0; i < 4000; i++) begin
            step();
            fifo_en    = ($urandom % 8) != 0;
            en_line    = $urandom % 2; en_rxd = $urandom % 2;
            en_thre    = ($urandom % 4) != 0; en_modem = $urandom % 2;
            line_err   = ($urandom % 5) == 0; rx_ready = ($urandom % 4) == 0;
            rx_timeout = ($urandom % 4) == 0; thr_empty = ($urandom % 5) != 0;
            modem_chg  = $urandom % 2;
            thr_wr     = ($urandom % 6) == 0; iid_rd = ($urandom % 3) == 0;
            if (i % 997 == 500) rst_n = 0; else rst_n = 1;
        end
        step();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule